// File: doc/BRIEF.md
# Banked GPIO Controller with Set/Clear Strobes

This block is a memory-mapped general purpose I/O controller for 128 pins, grouped as four ports of 32 pins each. Pin n lives in port (n/32) mod 4 at bit n mod 32. Software never writes an output or direction word directly. It writes a mask to a set strobe, which forces the masked bits to 1, or to a clear strobe, which forces them to 0. Bits that are 0 in the mask keep their state, so separate agents can work on disjoint pins without read-modify-write races.

Ports 0 and 1 each own a direction register. Ports 2 and 3 share a single one, so bit n of that register enables the output driver of pin n in both port 2 and port 3. Input pins pass through a two-flop synchroniser before they can be read. Read data is registered and returned one cycle after the address is presented.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset (rst_n low) is held and after it is released, every output latch is 0, every output enable is 0 (all pins are inputs) and rd_data is 0.
- R2: A write to output-set address 0x10 + 4*p drives gpio_out bits of port p high where wr_data is 1; other bits of every port keep their value.
- R3: A write to output-clear address 0x20 + 4*p drives gpio_out bits of port p low where wr_data is 1; other bits keep their value.
- R4: Direction-set writes (0x30 port 0, 0x34 port 1) set gpio_oe bits of that port where wr_data is 1 (pin becomes output); direction-clear writes (0x40, 0x44) clear them (pin becomes input); unmasked bits keep their state.
- R5: Ports 2 and 3 share one direction register, set at 0x38 and cleared at 0x48; gpio_oe bit n of port 2 and of port 3 always equal bit n of that register.
- R6: A read of input-state address 0x00 + 4*p returns the level of port p's pins as sampled through two synchroniser flops; a pin change is visible in rd_data three clock edges after it.
- R7: rd_data is registered: it shows the word for the address on addr at the previous rising edge. Direction readback is at 0x50 (port 0), 0x54 (port 1) and 0x58 (shared ports 2/3).
- R8: Reads of the write-only strobe addresses (0x10 to 0x4C) and of unmapped addresses return 0; writes to read-only or unmapped addresses (including 0x3C, 0x4C and any address with addr[1:0] not 00) change no output latch and no direction bit.
- R9: An output latch written while its pin is an input keeps the new value on gpio_out, and that value is driven (gpio_oe high) as soon as the pin is made an output, with no further output write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | PORT_W | Write data / bit mask |
| rd_data | output | PORT_W | Registered read data |
| gpio_in | input | 4*PORT_W | Pin levels from the pads |
| gpio_out | output | 4*PORT_W | Output latch values to the pads |
| gpio_oe | output | 4*PORT_W | Output driver enables to the pads |

## Verification
The bench builds the block with its default values, PORT_W of 32 and an 8-bit address, which gives the full 128-pin map so every port, the shared direction register and each unmapped hole of the address space can be hit. Distinct masks per port let a write that leaks into the wrong port or the wrong direction group show up at the pins. The three-edge input latency is probed by reading one edge too early and again at the settled point.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_PORTS   = 4;
  localparam int NUM_DIRGRP  = 3;

  localparam logic [3:0] RG_INPUT = 4'h0;
  localparam logic [3:0] RG_OSET  = 4'h1;
  localparam logic [3:0] RG_OCLR  = 4'h2;
  localparam logic [3:0] RG_DSET  = 4'h3;
  localparam logic [3:0] RG_DCLR  = 4'h4;
  localparam logic [3:0] RG_DSTAT = 4'h5;

  function automatic logic [3:0] region_of(input logic [7:0] a);
    return a[7:4];
  endfunction

  function automatic logic [1:0] index_of(input logic [7:0] a);
    return a[3:2];
  endfunction

  // port 0 -> group 0, port 1 -> group 1, ports 2 and 3 -> group 2
  function automatic int dir_group(input int port);
    return (port < 2) ? port : 2;
  endfunction
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  output logic [NUM_PORTS-1:0] out_set_hit,
  output logic [NUM_PORTS-1:0] out_clr_hit,
  output logic [NUM_DIRGRP-1:0] dir_set_hit,
  output logic [NUM_DIRGRP-1:0] dir_clr_hit,
  output logic                 aligned,
  output logic [3:0]           region,
  output logic [1:0]           index
);
  logic [7:0] low_addr;
  logic       hi_zero;

  assign low_addr = addr[7:0];
  assign hi_zero  = (addr >> 8) == '0;
  assign aligned  = hi_zero && (low_addr[1:0] == 2'b00);
  assign region   = region_of(low_addr);
  assign index    = index_of(low_addr);

  always_comb begin
    out_set_hit = '0;
    out_clr_hit = '0;
    dir_set_hit = '0;
    dir_clr_hit = '0;
    if (wr_en && aligned) begin
      unique case (region)
        RG_OSET: out_set_hit[index] = 1'b1;
        RG_OCLR: out_clr_hit[index] = 1'b1;
        RG_DSET: if (index < 2'd3) dir_set_hit[index] = 1'b1;
        RG_DCLR: if (index < 2'd3) dir_clr_hit[index] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mask_latch.sv
module gpio_mask_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_hit,
  input  logic         clr_hit,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (set_hit) q <= q | mask;
    else if (clr_hit) q <= q & ~mask;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PORT_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  logic [PORT_W-1:0]           wr_data,
  output logic [PORT_W-1:0]           rd_data,
  input  logic [NUM_PORTS*PORT_W-1:0] gpio_in,
  output logic [NUM_PORTS*PORT_W-1:0] gpio_out,
  output logic [NUM_PORTS*PORT_W-1:0] gpio_oe
);
  logic [NUM_PORTS-1:0]  out_set_hit, out_clr_hit;
  logic [NUM_DIRGRP-1:0] dir_set_hit, dir_clr_hit;
  logic                  aligned;
  logic [3:0]            region;
  logic [1:0]            index;
  logic [PORT_W-1:0]     in_word  [NUM_PORTS];
  logic [PORT_W-1:0]     out_word [NUM_PORTS];
  logic [PORT_W-1:0]     dir_word [NUM_DIRGRP];
  logic [PORT_W-1:0]     rd_next;

  gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en),
    .out_set_hit(out_set_hit), .out_clr_hit(out_clr_hit),
    .dir_set_hit(dir_set_hit), .dir_clr_hit(dir_clr_hit),
    .aligned(aligned), .region(region), .index(index)
  );

  for (genvar g = 0; g < NUM_DIRGRP; g++) begin : g_dir
    gpio_mask_latch #(.W(PORT_W)) u_dir (
      .clk(clk), .rst_n(rst_n),
      .set_hit(dir_set_hit[g]), .clr_hit(dir_clr_hit[g]),
      .mask(wr_data), .q(dir_word[g])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_mask_latch #(.W(PORT_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .set_hit(out_set_hit[p]), .clr_hit(out_clr_hit[p]),
      .mask(wr_data), .q(out_word[p])
    );
    gpio_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d(gpio_in[p*PORT_W +: PORT_W]), .q(in_word[p])
    );
    assign gpio_out[p*PORT_W +: PORT_W] = out_word[p];
    assign gpio_oe[p*PORT_W +: PORT_W]  = dir_word[dir_group(p)];
  end

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      case (region)
        RG_INPUT: rd_next = in_word[index];
        RG_DSTAT: if (index < 2'd3) rd_next = dir_word[index];
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int PORT_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [PORT_W-1:0]           wr_data,
  input logic [PORT_W-1:0]           rd_data,
  input logic [NUM_PORTS*PORT_W-1:0] gpio_out,
  input logic [NUM_PORTS*PORT_W-1:0] gpio_oe,
  input logic [NUM_PORTS-1:0]        out_set_hit,
  input logic [NUM_PORTS-1:0]        out_clr_hit,
  input logic [NUM_DIRGRP-1:0]       dir_set_hit,
  input logic [NUM_DIRGRP-1:0]       dir_clr_hit
);
  // R1: reset holds every pin as an input with a zero latch and zero read data
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (gpio_oe == '0 && gpio_out == '0 && rd_data == '0));

  // R8: at most one strobe fires per cycle
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_set_hit, out_clr_hit, dir_set_hit, dir_clr_hit}));

  // R8: no output strobe means no output change
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_set_hit == '0 && out_clr_hit == '0) |=> $stable(gpio_out));

  // R8: no direction strobe means no direction change
  a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_set_hit == '0 && dir_clr_hit == '0) |=> $stable(gpio_oe));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    localparam int G = dir_group(p);
    // R2
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      out_set_hit[p] |=>
        ((gpio_out[p*PORT_W +: PORT_W] & $past(wr_data)) == $past(wr_data)));
    // R3
    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      out_clr_hit[p] |=> ((gpio_out[p*PORT_W +: PORT_W] & $past(wr_data)) == '0));
    // R4 and R5: group write reaches every port of the group
    a_r4_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
      dir_set_hit[G] |=>
        ((gpio_oe[p*PORT_W +: PORT_W] & $past(wr_data)) == $past(wr_data)));
    a_r4_dir_clr: assert property (@(posedge clk) disable iff (!rst_n)
      dir_clr_hit[G] |=> ((gpio_oe[p*PORT_W +: PORT_W] & $past(wr_data)) == '0));
  end

  // R5: the two ports sharing a direction register always agree
  a_r5_shared_dir: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_oe[2*PORT_W +: PORT_W] == gpio_oe[3*PORT_W +: PORT_W]);
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .rd_data(rd_data),
  .gpio_out(gpio_out), .gpio_oe(gpio_oe),
  .out_set_hit(out_set_hit), .out_clr_hit(out_clr_hit),
  .dir_set_hit(dir_set_hit), .dir_clr_hit(dir_clr_hit)
);

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
  localparam int W  = 32;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;
  logic [NP*W-1:0] gpio_in = '0;
  logic [NP*W-1:0] gpio_out;
  logic [NP*W-1:0] gpio_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  // addr, data, port to check, expected out word, expected oe word, requirement
  typedef struct packed {
    logic [7:0]   a;
    logic [31:0]  d;
    logic [1:0]   port;
    logic [31:0]  eout;
    logic [31:0]  eoe;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 32'h0000_00FF, 2'd0, 32'h0000_00FF, 32'h0000_0000, 4'd2}, // R2
    '{8'h20, 32'h0000_000F, 2'd0, 32'h0000_00F0, 32'h0000_0000, 4'd3}, // R3
    '{8'h30, 32'hFFFF_0000, 2'd0, 32'h0000_00F0, 32'hFFFF_0000, 4'd4}, // R4
    '{8'h40, 32'h0F00_0000, 2'd0, 32'h0000_00F0, 32'hF0FF_0000, 4'd4}, // R4
    '{8'h14, 32'hA5A5_A5A5, 2'd1, 32'hA5A5_A5A5, 32'h0000_0000, 4'd2}, // R2
    '{8'h34, 32'h0000_FFFF, 2'd1, 32'hA5A5_A5A5, 32'h0000_FFFF, 4'd4}, // R4
    '{8'h38, 32'h1234_5678, 2'd2, 32'h0000_0000, 32'h1234_5678, 4'd5}, // R5
    '{8'h48, 32'h0000_0078, 2'd3, 32'h0000_0000, 32'h1234_5600, 4'd5}, // R5
    '{8'h1C, 32'hDEAD_BEEF, 2'd3, 32'hDEAD_BEEF, 32'h1234_5600, 4'd2}, // R2
    '{8'h2C, 32'hFFFF_0000, 2'd3, 32'h0000_BEEF, 32'h1234_5600, 4'd3}, // R3
    '{8'h3C, 32'hFFFF_FFFF, 2'd3, 32'h0000_BEEF, 32'h1234_5600, 4'd8}, // R8
    '{8'h00, 32'hFFFF_FFFF, 2'd0, 32'h0000_00F0, 32'hF0FF_0000, 4'd8}, // R8
    '{8'h11, 32'hFFFF_FFFF, 2'd0, 32'h0000_00F0, 32'hF0FF_0000, 4'd8}  // R8
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'hFC;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic [W-1:0] pw(input logic [NP*W-1:0] v, input int p);
    return v[p*W +: W];
  endfunction

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 out in reset", gpio_out[W-1:0] | gpio_out[NP*W-1:W], '0);
    check("R1 oe in reset", gpio_oe[W-1:0] | gpio_oe[NP*W-1:W], '0);
    rst_n = 1'b1;
    rd(8'h50, r); check("R1 dir readback after reset", r, '0);
    check("R1 rd_data after reset", rd_data, '0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].d);
      check($sformatf("R%0d vec%0d out", VECS[i].req, i), pw(gpio_out, VECS[i].port), VECS[i].eout);
      check($sformatf("R%0d vec%0d oe", VECS[i].req, i), pw(gpio_oe, VECS[i].port), VECS[i].eoe);
    end
    // R5: port 2 follows the shared register too
    check("R5 port2 oe shared", pw(gpio_oe, 2), 32'h1234_5600);
    check("R2 port2 out untouched", pw(gpio_out, 2), '0);

    // R7: direction readback
    rd(8'h50, r); check("R7 dir0 readback", r, 32'hF0FF_0000);
    rd(8'h54, r); check("R7 dir1 readback", r, 32'h0000_FFFF);
    rd(8'h58, r); check("R7 dir23 readback", r, 32'h1234_5600);

    // R8: strobe and unmapped reads give 0
    rd(8'h14, r); check("R8 read out-set is 0", r, '0);
    rd(8'h34, r); check("R8 read dir-set is 0", r, '0);
    rd(8'h5C, r); check("R8 read unmapped is 0", r, '0);
    rd(8'h51, r); check("R8 misaligned read is 0", r, '0);

    // R6: synchroniser latency
    @(negedge clk);
    gpio_in[2*W +: W] = 32'hCAFE_F00D;
    addr = 8'h08;
    @(negedge clk);
    check("R6 one edge after pin change", rd_data, '0);
    @(negedge clk);
    check("R6 two edges after pin change", rd_data, '0);
    @(negedge clk);
    check("R6 three edges after pin change", rd_data, 32'hCAFE_F00D);
    gpio_in[1*W +: W] = 32'h0BAD_0001;
    repeat (3) @(negedge clk);
    rd(8'h04, r); check("R6 port1 input", r, 32'h0BAD_0001);
    rd(8'h0C, r); check("R6 port3 input", r, '0);

    // R9: latch written while input, driven after direction set
    wr(8'h18, 32'h0000_00FF);
    check("R9 latch held while input", pw(gpio_out, 2) & 32'hFF, 32'hFF);
    check("R9 not driven while input", pw(gpio_oe, 2) & 32'hFF, '0);
    wr(8'h38, 32'h0000_00FF);
    check("R9 driven after dir set", pw(gpio_oe, 2) & pw(gpio_out, 2) & 32'hFF, 32'hFF);
    check("R5 port3 gets shared dir set", pw(gpio_oe, 3) & 32'hFF, 32'hFF);

    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 out after re-reset", gpio_out[W-1:0] | gpio_out[NP*W-1:W], '0);
    check("R1 oe after re-reset", gpio_oe[W-1:0] | gpio_oe[NP*W-1:W], '0);
    check("R1 rd_data after re-reset", rd_data, '0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule